// File: doc/BRIEF.md
# Byte-Level Two-Wire Bus Master with Status Codes

This block drives a two-wire serial bus (I2C) as the only master, one byte at a time, under the control of a small register port. Software writes a command into the control register: generate a START, move one byte, or generate a STOP. The core runs that step on the bus and then raises its flag (also presented as `irq`). It reports a numeric status code that names the event which just ended. While the flag is up, the core holds the clock line low, so the bus waits for software to issue the next command.

A received or transmitted byte passes through a single data register. The first byte after any START is the address byte: a 7-bit target address in bits 7:1 and the direction in bit 0. That bit decides whether the bytes that follow are sent or received. The bus clock comes from a divider with two fields and a fixed high-phase factor. Each bus bit is built from four equal quarter steps, so SDA only ever moves while SCL is low, except for the START and STOP conditions themselves.

Both bus lines are open drain. The `scl_pull` and `sda_pull` outputs mean "drive this line low", and `sda_in` returns the resolved level of the data line.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status reads 0xF8, the flag is clear, and neither bus line is pulled low.
- R2: Register select 0 is the data register. Select 1 is control, with AAK in bit 2, the flag in bit 3, STP in bit 4, STA in bit 5, ENAB in bit 6 and CE in bit 7; STA and STP read back as 1 while their sequence is running. A write to select 2 loads the clock control, and a read of select 2 returns the status. Select 3 reads zero.
- R3: A control write with STA and ENAB set, made while no sequence is running, generates a START. When the START ends, the flag is set and the status is 0x08 if the bus was free, or 0x10 if the core already owned the bus (repeated start).
- R4: The first byte after a START is sent MSB first from the data register, and its bit 0 selects the direction (0 write, 1 read). A low SDA in the ninth bit counts as ACK. The status is then 0x18 (ACK) or 0x20 (NACK) for a write address, and 0x40 (ACK) or 0x48 (NACK) for a read address.
- R5: In write direction each later byte is sent MSB first from the data register, ending with status 0x28 on ACK or 0x30 on NACK.
- R6: In read direction each byte is shifted MSB first into the data register. In the ninth bit the master pulls SDA low (ACK) if AAK was set in the control write that started the byte, and releases it (NACK) otherwise. The status is then 0x50 or 0x58.
- R7: A control write with ENAB set and STA, STP and the flag bit all clear starts the next byte only while the flag is set; the write clears the flag. Control writes with ENAB clear, or with the flag bit written 1, start nothing and leave the flag, the status and the bus lines unchanged.
- R8: While the flag is set after a START or a byte, SCL is held low.
- R9: A control write with STP and ENAB set while the core owns the bus generates a STOP. At its end the status is 0xF8, the flag stays clear and both lines are released.
- R10: SDA changes while SCL is high only as the START edge (falling) or the STOP edge (rising).
- R11: If a bit the master leaves released reads back low during the eight data bits of a transmitted byte, the master releases both lines at once, sets the flag with status 0x38 and no longer owns the bus, so the next START reports 0x08.
- R12: Clock control holds M in bits 6:3 and N in bits 2:0. One SCL period lasts 20·(M+1)·(THP+1)·2^N clock cycles, with THP a parameter of default 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| irq | output | 1 | Step-complete flag |
| scl_pull | output | 1 | Pull SCL low when 1 |
| sda_pull | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA line level |

## Verification
The assertions watch, on every cycle, that SCL stays low while the flag waits after a normal step, that SDA moves under a high SCL only inside a START or STOP sequence, and that both lines are released in the idle state and after lost arbitration. They also check that the flag only rises together with a legal step code. Only the bench scenarios, run against a behavioural target on the bus, can show that each code matches the bus event that really happened. The same holds for the bytes that arrive at and come back from the target, for the ACK or NACK the master returns, and for the SCL period measured across a sweep of M and N.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int THP = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic       sda_in
);
  localparam int QMAX = 5 * 16 * (THP + 1) * 128;
  localparam int CW = $clog2(QMAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;

  st_t         st;
  logic [1:0]  q;
  logic [3:0]  bitn;
  logic [CW-1:0] cnt, qlen;
  logic [7:0]  data, status;
  logic        iflg, aak, enab, ce, owned, first, rxm, sda_r, ack_r;
  logic [3:0]  mdiv;
  logic [2:0]  ndiv;

  assign qlen = (CW'(5 * (THP + 1)) * (CW'(mdiv) + CW'(1))) << ndiv;

  wire tick   = (st != S_IDLE) && (cnt == qlen - CW'(1));
  wire xmit   = first | ~rxm;
  wire idle   = (st == S_IDLE);
  wire ctl_wr = reg_we && reg_addr == 2'd1 && idle;
  wire cmd_en = ctl_wr && reg_wdata[6];
  wire go_start = cmd_en && reg_wdata[5];
  wire go_stop  = cmd_en && !reg_wdata[5] && reg_wdata[4] && owned;
  wire go_byte  = cmd_en && !reg_wdata[5] && !reg_wdata[4] && !reg_wdata[3] && iflg && owned;
  wire seq_edge = (st == S_START) || (st == S_STOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; bitn <= '0; cnt <= '0;
      data <= '0; status <= 8'hF8; iflg <= 1'b0;
      aak <= 1'b0; enab <= 1'b0; ce <= 1'b0;
      owned <= 1'b0; first <= 1'b0; rxm <= 1'b0; sda_r <= 1'b0; ack_r <= 1'b0;
      mdiv <= '0; ndiv <= '0;
    end else if (idle) begin
      cnt <= '0;
      q <= '0;
      bitn <= '0;
      if (reg_we && reg_addr == 2'd0) data <= reg_wdata;
      if (reg_we && reg_addr == 2'd2) {mdiv, ndiv} <= reg_wdata[6:0];
      if (ctl_wr) begin
        ce <= reg_wdata[7];
        enab <= reg_wdata[6];
        aak <= reg_wdata[2];
      end
      if (go_start) begin st <= S_START; iflg <= 1'b0; end
      else if (go_stop) begin st <= S_STOP; iflg <= 1'b0; end
      else if (go_byte) begin st <= S_BIT; iflg <= 1'b0; end
    end else if (!tick) begin
      cnt <= cnt + CW'(1);
    end else begin
      cnt <= '0;
      q <= q + 2'd1;
      case (st)
        S_START: begin
          if (q == 2'd0) sda_r <= 1'b0;
          if (q == 2'd1) sda_r <= 1'b1;
          if (q == 2'd3) begin
            st <= S_IDLE;
            iflg <= 1'b1;
            status <= owned ? 8'h10 : 8'h08;
            owned <= 1'b1;
            first <= 1'b1;
          end
        end
        S_BIT: begin
          if (q == 2'd0)
            sda_r <= (bitn < 4'd8) ? (xmit & ~data[7]) : (~xmit & aak);
          if (q == 2'd2) begin
            if (bitn < 4'd8) begin
              data <= {data[6:0], sda_in};
              if (xmit && !sda_r && !sda_in) begin
                st <= S_IDLE;
                sda_r <= 1'b0;
                owned <= 1'b0;
                iflg <= 1'b1;
                status <= 8'h38;
              end
            end else begin
              ack_r <= ~sda_in;
            end
          end
          if (q == 2'd3) begin
            if (bitn == 4'd8) begin
              st <= S_IDLE;
              iflg <= 1'b1;
              first <= 1'b0;
              if (first) rxm <= data[0];
              if (first)
                status <= data[0] ? (ack_r ? 8'h40 : 8'h48) : (ack_r ? 8'h18 : 8'h20);
              else if (rxm)
                status <= aak ? 8'h50 : 8'h58;
              else
                status <= ack_r ? 8'h28 : 8'h30;
            end else begin
              bitn <= bitn + 4'd1;
            end
          end
        end
        S_STOP: begin
          if (q == 2'd0) sda_r <= 1'b1;
          if (q == 2'd2) sda_r <= 1'b0;
          if (q == 2'd3) begin
            st <= S_IDLE;
            owned <= 1'b0;
            status <= 8'hF8;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_START: scl_pull = (q == 2'd0) ? owned : (q == 2'd3);
      S_BIT:   scl_pull = (q < 2'd2);
      S_STOP:  scl_pull = (q < 2'd2);
      default: scl_pull = owned;
    endcase
  end

  assign sda_pull = sda_r;
  assign irq = iflg;

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = data;
      2'd1: reg_rdata = {ce, enab, st == S_START, st == S_STOP, iflg, aak, 2'b00};
      2'd2: reg_rdata = status;
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       scl_pull,
  input logic       sda_pull,
  input logic [7:0] status,
  input logic       seq_edge,
  input logic       idle
);
  // R8
  stretch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && status != 8'h38) |-> scl_pull);

  // R10
  sda_high_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_pull) && !scl_pull && (sda_pull != $past(sda_pull))) |-> $past(seq_edge));

  // R9
  stopped_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && status == 8'hF8) |-> (!scl_pull && !sda_pull && !irq));

  // R11
  lost_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && irq && status == 8'h38) |-> (!scl_pull && !sda_pull));

  // R3
  flag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status inside {8'h08, 8'h10, 8'h18, 8'h20, 8'h28, 8'h30,
                                   8'h38, 8'h40, 8'h48, 8'h50, 8'h58}));

  // R7
  flag_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> idle);
endmodule

bind i2c_byte_master i2c_byte_master_chk chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .status(status), .seq_edge(seq_edge), .idle(idle)
);

// File: tb/i2c_byte_master_test.sv
module i2c_byte_master_test;
  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  wire  [7:0] reg_rdata;
  wire irq, scl_pull, sda_pull;
  logic slv_pull = 1'b0, jam = 1'b0, nack_data = 1'b0;
  wire scl_line = ~scl_pull;
  wire sda_line = ~(sda_pull | slv_pull | jam);

  i2c_byte_master #(.THP(0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_line)
  );

  always #10 clk = ~clk;

  localparam logic [6:0] TGT = 7'h2A;
  int checks = 0, errors = 0;

  function automatic logic [7:0] pat(input int k);
    return 8'hC3 ^ 8'(k * 37);
  endfunction

  // behavioural bus target
  logic pscl = 1'b1, psda = 1'b1, is_addr = 1'b0, rdm = 1'b0, sel = 1'b0, mack = 1'b0;
  logic [7:0] sh = '0, txb = '0;
  logic [7:0] wlog [0:7];
  int bc = 0, wcnt = 0, txcnt = 0;

  always @(posedge clk) begin
    pscl <= scl_line;
    psda <= sda_line;
    if (pscl && scl_line && psda && !sda_line) begin
      bc <= 0; is_addr <= 1'b1; slv_pull <= 1'b0;
    end else if (pscl && scl_line && !psda && sda_line) begin
      slv_pull <= 1'b0; sel <= 1'b0;
    end else if (!pscl && scl_line) begin
      if (bc < 8) sh <= {sh[6:0], sda_line};
      else if (rdm && !is_addr) mack <= !sda_line;
      bc <= bc + 1;
    end else if (pscl && !scl_line) begin
      if (bc == 8) begin
        if (is_addr) slv_pull <= (sh[7:1] == TGT);
        else if (!rdm) begin
          slv_pull <= sel && !nack_data;
          if (sel && wcnt < 8) begin wlog[wcnt] <= sh; wcnt <= wcnt + 1; end
        end else slv_pull <= 1'b0;
      end else if (bc == 9) begin
        bc <= 0;
        if (is_addr) begin
          is_addr <= 1'b0;
          rdm <= sh[0];
          sel <= (sh[7:1] == TGT);
          if (sh[7:1] == TGT && sh[0]) begin
            txb <= pat(0); txcnt <= 1; slv_pull <= !pat(0)[7];
          end else slv_pull <= 1'b0;
        end else if (rdm && sel && mack) begin
          txb <= pat(txcnt); txcnt <= txcnt + 1; slv_pull <= !pat(txcnt)[7];
        end else slv_pull <= 1'b0;
      end else if (bc >= 1 && bc <= 7 && rdm && !is_addr && sel) begin
        slv_pull <= !txb[7 - bc];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_irq;
    for (int n = 0; n < 20000 && !irq; n++) @(negedge clk);
  endtask

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_stop;
    logic [7:0] c;
    for (int n = 0; n < 20000; n++) begin
      rd(2'd1, c);
      if (!c[4]) break;
    end
  endtask

  task automatic step(input logic [7:0] ctl, input logic [7:0] exp, input string req);
    logic [7:0] s;
    wr(2'd1, ctl);
    wait_irq();
    rd(2'd2, s);
    chk(req, s, exp);
  endtask

  task automatic addr_byte(input logic [7:0] a, input logic [7:0] exp, input string req);
    wr(2'd0, a);
    step(8'h40, exp, req);
  endtask

  task automatic stop_seq;
    wr(2'd1, 8'h50);
    wait_stop();
  endtask

  initial begin
    #(20 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] wb [0:2];
    wb[0] = 8'h5A; wb[1] = 8'h01; wb[2] = 8'hFE;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd2, v); chk("R1 status", v, 8'hF8);
    chk("R1 flag", irq, 1'b0);
    chk("R1 lines", {scl_pull, sda_pull}, 2'b00);
    rd(2'd3, v); chk("R2 select 3", v, 8'h00);

    wr(2'd1, 8'hC4);
    rd(2'd1, v); chk("R2 control readback", v, 8'hC4);
    chk("R7 resume without flag", {irq, scl_pull}, 2'b00);
    wr(2'd1, 8'h20);
    idle_wait(60);
    chk("R7 ENAB clear no start", {irq, scl_pull, sda_pull}, 3'b000);
    rd(2'd2, v); chk("R7 ENAB clear status", v, 8'hF8);

    step(8'h60, 8'h08, "R3 start from free bus");
    chk("R8 SCL held", scl_pull, 1'b1);
    rd(2'd1, v); chk("R2 flag bit", v[3], 1'b1);
    wcnt = 0;
    addr_byte({TGT, 1'b0}, 8'h18, "R4 write address ACK");
    for (int i = 0; i < 3; i++) begin
      wr(2'd0, wb[i]);
      step(8'h40, 8'h28, "R5 data ACK");
    end
    chk("R5 byte count", wcnt, 3);
    for (int i = 0; i < 3; i++) chk("R5 target byte", wlog[i], wb[i]);
    wr(2'd1, 8'h48);
    idle_wait(60);
    chk("R7 flag bit written 1", irq, 1'b1);
    rd(2'd2, v); chk("R7 status kept", v, 8'h28);

    step(8'h60, 8'h10, "R3 repeated start");
    addr_byte({TGT, 1'b1}, 8'h40, "R4 read address ACK");
    for (int i = 0; i < 4; i++) begin
      step((i < 3) ? 8'h44 : 8'h40, (i < 3) ? 8'h50 : 8'h58, "R6 receive status");
      rd(2'd0, v); chk("R6 received byte", v, pat(i));
      chk("R6 master ACK bit", mack, (i < 3) ? 1'b1 : 1'b0);
    end
    stop_seq();
    rd(2'd2, v); chk("R9 status after stop", v, 8'hF8);
    chk("R9 lines and flag", {irq, scl_pull, sda_pull}, 3'b000);
    idle_wait(60);
    chk("R9 flag stays clear", irq, 1'b0);

    step(8'h60, 8'h08, "R3 start");
    addr_byte({7'h11, 1'b0}, 8'h20, "R4 write address NACK");
    stop_seq();
    step(8'h60, 8'h08, "R3 start");
    addr_byte({7'h11, 1'b1}, 8'h48, "R4 read address NACK");
    stop_seq();

    nack_data = 1'b1;
    step(8'h60, 8'h08, "R3 start");
    addr_byte({TGT, 1'b0}, 8'h18, "R4 write address ACK");
    wr(2'd0, 8'h33);
    step(8'h40, 8'h30, "R5 data NACK");
    stop_seq();
    nack_data = 1'b0;

    step(8'h60, 8'h08, "R3 start");
    addr_byte({TGT, 1'b0}, 8'h18, "R4 write address ACK");
    wr(2'd0, 8'hFF);
    jam = 1'b1;
    step(8'h40, 8'h38, "R11 lost arbitration code");
    idle_wait(2);
    chk("R11 lines released", {scl_pull, sda_pull}, 2'b00);
    jam = 1'b0;
    idle_wait(20);
    step(8'h60, 8'h08, "R11 bus no longer owned");
    stop_seq();

    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 3; n++) begin
        int t1, t2;
        wr(2'd2, 8'((m << 3) | n));
        step(8'h60, 8'h08, "R3 start");
        wr(2'd0, {TGT, 1'b0});
        wr(2'd1, 8'h40);
        t1 = 0; t2 = 0;
        while (!scl_line) @(negedge clk);
        while (scl_line) begin @(negedge clk); t1++; end
        while (!scl_line) begin @(negedge clk); t2++; end
        chk("R12 SCL period", t1 + t2, 20 * (m + 1) * (1 << n));
        wait_irq();
        rd(2'd2, v); chk("R12 address status", v, 8'h18);
        stop_seq();
      end
    end
    wr(2'd2, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule